// File: doc/BRIEF.md
# DMA Event Latch and Clear

This block holds the pending state of 64 DMA trigger events. A one-cycle pulse on an event input makes that event's pending bit set, and the bit stays set. A per-event enable mask decides which pending events may become transfer requests. A small request state machine offers one enabled, pending event at a time on a valid/ready request port. It always picks the lowest-numbered candidate. When the request is accepted, the pending bit of that event is cleared automatically.

A processor reaches the block through a simple synchronous register bus. It can read the pending bits and read or write the enable mask, 32 events per word. It can also discard pending events through two write-one-to-clear words. This is the only way to remove an event that is disabled, because a disabled event is never requested.

The request state machine has two states. In `ST_IDLE` no request is offered. The transition *pick* moves it to `ST_OFFER` in the cycle after an enabled pending event exists, and it captures that event's index at the same edge. In `ST_OFFER` the request is held. The transition *accept* returns it to `ST_IDLE` on the edge where `req_ready` is high.

Top module: `dma_evt_latch`

## Requirements
- R1: After reset all pending bits and all enable bits are 0, `req_valid` is low and `bus_rdata` is 0.
- R2: Event n maps to word n/32, bit n%32. Word addresses are: 0 = pending events 0–31, 1 = pending events 32–63, 2 = enable 0–31, 3 = enable 32–63, 4 = clear 0–31, 5 = clear 32–63. `bus_rdata` is registered and shows the word addressed in the previous cycle.
- R3: A pulse on `evt_pulse[n]` sets pending bit n at the next edge. The bit stays set until its request is accepted or the processor clears it. A repeated pulse on a bit that is already set changes nothing.
- R4: An event whose enable bit is 0 is never offered on the request port, and its pending bit stays set.
- R5: A write to a clear word clears each pending bit whose data bit is 1. Pending bits whose data bit is 0 are unchanged.
- R6: Reads of the clear-word addresses (4, 5) return 0.
- R7: The enable words are read/write, and a write replaces the whole 32-bit word.
- R8: When a request is formed, it carries the lowest-numbered event that was pending and enabled in the cycle before `req_valid` rose.
- R9: `req_valid` rises one cycle after an enabled event is pending. While `req_ready` is low, `req_valid` stays high and `req_idx` (6-bit event number) stays stable.
- R10: On the edge where `req_valid` and `req_ready` are both high, the offered event's pending bit clears. `req_valid` is low in the following cycle.
- R11: A pulse on an event in the same cycle as a clear of that bit leaves the bit pending. The clear may be a processor clear or a request acceptance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_pulse | input | 64 | One-cycle event trigger pulses, bit n = event n |
| bus_addr | input | 3 | Register word address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the previous cycle's address |
| req_valid | output | 1 | Transfer request offered |
| req_idx | output | 6 | Event number of the offered request |
| req_ready | input | 1 | Request accepted when high with `req_valid` |

## Verification
On every cycle, the assertions check the following:
- pending bits stay set unless a clear path hits them;
- a set beats a clear;
- a processor clear removes its bits;
- a held request stays stable until accepted and drops after acceptance;
- a newly raised request names an enabled, pending event with no lower candidate;
- clear-word reads return zero.

Only the directed scenarios can show behaviour that needs a specific sequence:
- the address-to-word mapping and the read-back of chosen values;
- that zero data bits in a clear word leave their events alone;
- the full lowest-first service order, including a lower event arriving while a higher one is held;
- a pulse colliding with an acceptance, which causes the same event to be requested again.

// File: rtl/dmaev_pkg.sv
package dmaev_pkg;

    // Request state machine states
    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_OFFER = 1'b1
    } req_state_e;

    // Register groups, each NUM_WORDS words long, laid out in this order
    localparam int GRP_PEND = 0;
    localparam int GRP_ENA  = 1;
    localparam int GRP_CLR  = 2;
    localparam int GRP_CNT  = 3;

endpackage

// File: rtl/evt_pend_bank.sv
module evt_pend_bank #(
    parameter int NUM_EVT = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EVT-1:0] set_v,
    input  logic [NUM_EVT-1:0] cpu_clr_v,
    input  logic [NUM_EVT-1:0] acc_clr_v,
    output logic [NUM_EVT-1:0] pend_q
);

    logic [NUM_EVT-1:0] clr_any;

    always_comb begin
        clr_any = cpu_clr_v | acc_clr_v;
    end

    // Sticky pending bits; a set in the same cycle outranks any clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q <= (pend_q & ~clr_any) | set_v;
        end
    end

    // R3: a pending bit not hit by a clear remains set
    p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(pend_q) & ~$past(clr_any)) & ~pend_q) == '0));

    // R11: every pulsed bit is pending on the next cycle
    p_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(set_v) & ~pend_q) == '0));

    // R5: processor-cleared bits without a coincident set are gone
    p_cpu_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(cpu_clr_v) & ~$past(set_v)) & pend_q) == '0));

endmodule

// File: rtl/evt_pick.sv
module evt_pick #(
    parameter int NUM_EVT = 64,
    parameter int IDX_W   = 6
) (
    input  logic [NUM_EVT-1:0] cand_v,
    output logic               found,
    output logic [IDX_W-1:0]   pick_idx
);

    // Lowest-numbered candidate wins: scan downward so the last hit is lowest
    always_comb begin
        pick_idx = '0;
        for (int i = NUM_EVT - 1; i >= 0; i--) begin
            if (cand_v[i]) begin
                pick_idx = IDX_W'(i);
            end
        end
        found = |cand_v;
    end

endmodule

// File: rtl/evt_req_fsm.sv
module evt_req_fsm
    import dmaev_pkg::*;
#(
    parameter int NUM_EVT = 64,
    parameter int IDX_W   = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cand_found,
    input  logic [IDX_W-1:0]   cand_idx,
    input  logic               req_ready,
    output logic               req_valid,
    output logic [IDX_W-1:0]   req_idx,
    output logic [NUM_EVT-1:0] acc_clr_v
);

    req_state_e state_q, state_d;
    logic [IDX_W-1:0] held_idx_q;
    logic             do_pick;
    logic             do_accept;

    // Next-state and transition decode
    always_comb begin
        state_d   = state_q;
        do_pick   = 1'b0;
        do_accept = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (cand_found) begin
                    state_d = ST_OFFER;
                    do_pick = 1'b1;
                end
            end
            ST_OFFER: begin
                if (req_ready) begin
                    state_d   = ST_IDLE;
                    do_accept = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Offered event number, captured on the pick transition
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_idx_q <= '0;
        end else if (do_pick) begin
            held_idx_q <= cand_idx;
        end
    end

    // Outputs
    always_comb begin
        req_valid = (state_q == ST_OFFER);
        req_idx   = held_idx_q;
        acc_clr_v = '0;
        if (do_accept) begin
            acc_clr_v[held_idx_q] = 1'b1;
        end
    end

    // R9: an unaccepted request holds its index
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_idx)));

    // R10: acceptance is followed by a cycle without a request
    p_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_valid);

    // R10: at most one event is retired per cycle
    p_one_retire_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(acc_clr_v));

endmodule

// File: rtl/evt_regif.sv
module evt_regif
    import dmaev_pkg::*;
#(
    parameter int NUM_WORDS = 2,
    parameter int WORD_W    = 32,
    parameter int ADDR_W    = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic                        bus_wr,
    input  logic [WORD_W-1:0]           bus_wdata,
    input  logic [NUM_WORDS*WORD_W-1:0] pend_q,
    output logic [NUM_WORDS*WORD_W-1:0] ena_q,
    output logic [NUM_WORDS*WORD_W-1:0] cpu_clr_v,
    output logic [WORD_W-1:0]           bus_rdata
);

    logic [NUM_WORDS-1:0] hit_pend;
    logic [NUM_WORDS-1:0] hit_ena;
    logic [NUM_WORDS-1:0] hit_clr;
    logic [WORD_W-1:0]    rd_mux;

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        always_comb begin
            hit_pend[w] = (bus_addr == ADDR_W'(GRP_PEND * NUM_WORDS + w));
            hit_ena[w]  = (bus_addr == ADDR_W'(GRP_ENA  * NUM_WORDS + w));
            hit_clr[w]  = (bus_addr == ADDR_W'(GRP_CLR  * NUM_WORDS + w));
            cpu_clr_v[w*WORD_W +: WORD_W] = (bus_wr && hit_clr[w]) ? bus_wdata : '0;
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ena_q[w*WORD_W +: WORD_W] <= '0;
            end else if (bus_wr && hit_ena[w]) begin
                ena_q[w*WORD_W +: WORD_W] <= bus_wdata;
            end
        end

        // R7: an enable write is visible on the next cycle
        p_ena_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && hit_ena[w]) |=> (ena_q[w*WORD_W +: WORD_W] == $past(bus_wdata)));
    end

    // Read multiplexer; clear words and unused addresses contribute nothing
    always_comb begin
        rd_mux = '0;
        for (int w = 0; w < NUM_WORDS; w++) begin
            if (hit_pend[w]) rd_mux = rd_mux | pend_q[w*WORD_W +: WORD_W];
            if (hit_ena[w])  rd_mux = rd_mux | ena_q[w*WORD_W +: WORD_W];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else begin
            bus_rdata <= rd_mux;
        end
    end

    // R6: a clear-word address reads back as zero
    p_clr_reads_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (|hit_clr) |=> (bus_rdata == '0));

endmodule

// File: rtl/dma_evt_latch.sv
module dma_evt_latch
    import dmaev_pkg::*;
#(
    parameter int NUM_EVT = 64,
    parameter int WORD_W  = 32,
    localparam int NUM_WORDS = NUM_EVT / WORD_W,
    localparam int IDX_W     = $clog2(NUM_EVT),
    localparam int ADDR_W    = $clog2(GRP_CNT * NUM_WORDS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EVT-1:0] evt_pulse,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_wr,
    input  logic [WORD_W-1:0]  bus_wdata,
    output logic [WORD_W-1:0]  bus_rdata,
    output logic               req_valid,
    output logic [IDX_W-1:0]   req_idx,
    input  logic               req_ready
);

    localparam int SHW = IDX_W + 1;

    logic [NUM_EVT-1:0] pend_q;
    logic [NUM_EVT-1:0] ena_q;
    logic [NUM_EVT-1:0] cpu_clr_v;
    logic [NUM_EVT-1:0] acc_clr_v;
    logic [NUM_EVT-1:0] cand_v;
    logic               cand_found;
    logic [IDX_W-1:0]   cand_idx;

    always_comb begin
        cand_v = pend_q & ena_q;
    end

    evt_pend_bank #(.NUM_EVT(NUM_EVT)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_v     (evt_pulse),
        .cpu_clr_v (cpu_clr_v),
        .acc_clr_v (acc_clr_v),
        .pend_q    (pend_q)
    );

    evt_regif #(.NUM_WORDS(NUM_WORDS), .WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_regif (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .pend_q    (pend_q),
        .ena_q     (ena_q),
        .cpu_clr_v (cpu_clr_v),
        .bus_rdata (bus_rdata)
    );

    evt_pick #(.NUM_EVT(NUM_EVT), .IDX_W(IDX_W)) u_pick (
        .cand_v   (cand_v),
        .found    (cand_found),
        .pick_idx (cand_idx)
    );

    evt_req_fsm #(.NUM_EVT(NUM_EVT), .IDX_W(IDX_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cand_found (cand_found),
        .cand_idx   (cand_idx),
        .req_ready  (req_ready),
        .req_valid  (req_valid),
        .req_idx    (req_idx),
        .acc_clr_v  (acc_clr_v)
    );

    // R4: a new request names an event that was enabled and pending
    p_req_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_valid) |-> ((($past(cand_v) >> req_idx) & NUM_EVT'(1)) != '0));

    // R8: no lower-numbered candidate existed when the request was formed
    p_lowest_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_valid) |->
            (($past(cand_v) << (SHW'(NUM_EVT) - SHW'(req_idx))) == '0));

    // R10: the accepted event's bit is gone unless re-pulsed
    p_accept_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !evt_pulse[req_idx]) |=> !pend_q[$past(req_idx)]);

endmodule

// File: tb/dma_evt_latch_tb_top.sv
module dma_evt_latch_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [63:0] evt_pulse;
    logic [2:0]  bus_addr;
    logic        bus_wr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        req_valid;
    logic [5:0]  req_idx;
    logic        req_ready;

    int n_chk = 0;
    int n_err = 0;

    always #10 clk = ~clk;   // 50 MHz

    dma_evt_latch dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_pulse (evt_pulse),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .req_valid (req_valid),
        .req_idx   (req_idx),
        .req_ready (req_ready)
    );

    localparam logic [2:0] A_PLO = 3'd0, A_PHI = 3'd1, A_ELO = 3'd2,
                           A_EHI = 3'd3, A_CLO = 3'd4, A_CHI = 3'd5;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wr = 1'b0;
        @(negedge clk);
        d = bus_rdata;
    endtask

    task automatic pulse(input logic [63:0] v);
        @(negedge clk);
        evt_pulse = v;
        @(negedge clk);
        evt_pulse = '0;
    endtask

    // Wait for a request, check index, hold it, then accept
    task automatic accept(input string tag, input logic [5:0] exp_idx,
                          input int hold, input logic [63:0] inject);
        int waited = 0;
        while (!req_valid && waited < 10) begin
            @(negedge clk);
            waited++;
        end
        chk({tag, " R8 offered index"}, {58'd0, req_idx}, {58'd0, exp_idx});
        for (int h = 0; h < hold; h++) begin
            evt_pulse = (h == 0) ? inject : '0;
            @(negedge clk);
            chk({tag, " R9 held valid+index"}, {57'd0, req_valid, req_idx},
                {57'd0, 1'b1, exp_idx});
        end
        evt_pulse = '0;
        req_ready = 1'b1;
        @(negedge clk);
        req_ready = 1'b0;
        chk({tag, " R10 valid drops after accept"}, {63'd0, req_valid}, 64'd0);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R1 req_valid after reset", {63'd0, req_valid}, 64'd0);
        chk("R1 rdata after reset", {32'd0, bus_rdata}, 64'd0);
        bus_read(A_PLO, d); chk("R1 pending lo reset", {32'd0, d}, 64'd0);
        bus_read(A_PHI, d); chk("R1 pending hi reset", {32'd0, d}, 64'd0);
        bus_read(A_ELO, d); chk("R1 enable lo reset", {32'd0, d}, 64'd0);
        bus_read(A_EHI, d); chk("R1 enable hi reset", {32'd0, d}, 64'd0);
    endtask

    task automatic t_sticky_disabled();
        logic [31:0] d;
        pulse((64'd1 << 3) | (64'd1 << 7) | (64'd1 << 40) | (64'd1 << 63));
        repeat (4) @(negedge clk);
        bus_read(A_PLO, d); chk("R2 R3 pending lo sticky", {32'd0, d}, 64'h88);
        bus_read(A_PHI, d); chk("R2 R3 pending hi sticky", {32'd0, d}, 64'h8000_0100);
        chk("R4 disabled not requested", {63'd0, req_valid}, 64'd0);
        pulse(64'd1 << 3);
        bus_read(A_PLO, d); chk("R3 repeat pulse no change", {32'd0, d}, 64'h88);
    endtask

    task automatic t_clear_words();
        logic [31:0] d;
        bus_read(A_CLO, d); chk("R6 clear lo reads zero", {32'd0, d}, 64'd0);
        bus_read(A_CHI, d); chk("R6 clear hi reads zero", {32'd0, d}, 64'd0);
        bus_write(A_CLO, 32'h0);
        bus_read(A_PLO, d); chk("R5 zero write no effect", {32'd0, d}, 64'h88);
        bus_write(A_CLO, 32'h0000_0080);
        bus_read(A_PLO, d); chk("R5 clear lo bit7 only", {32'd0, d}, 64'h08);
        bus_write(A_CHI, 32'h8000_0000);
        bus_read(A_PHI, d); chk("R5 clear hi bit63 only", {32'd0, d}, 64'h100);
        bus_read(A_PLO, d); chk("R5 hi clear leaves lo", {32'd0, d}, 64'h08);
        bus_write(A_CLO, 32'h0000_0008);
        bus_write(A_CHI, 32'h0000_0100);
        bus_read(A_PLO, d); chk("R4 R5 disabled cleared by cpu lo", {32'd0, d}, 64'd0);
        bus_read(A_PHI, d); chk("R4 R5 disabled cleared by cpu hi", {32'd0, d}, 64'd0);
    endtask

    task automatic t_enable_rw();
        logic [31:0] d;
        bus_write(A_ELO, 32'hA5A5_0F0F);
        bus_write(A_EHI, 32'h1234_5678);
        bus_read(A_ELO, d); chk("R7 enable lo readback", {32'd0, d}, 64'hA5A5_0F0F);
        bus_read(A_EHI, d); chk("R7 enable hi readback", {32'd0, d}, 64'h1234_5678);
        bus_write(A_ELO, 32'h0);
        bus_write(A_EHI, 32'h0);
        bus_read(A_ELO, d); chk("R7 enable lo rewritten", {32'd0, d}, 64'd0);
    endtask

    task automatic t_priority();
        logic [31:0] d;
        pulse((64'd1 << 9) | (64'd1 << 2) | (64'd1 << 33) | (64'd1 << 60));
        bus_write(A_ELO, 32'hFFFF_FFFF);
        bus_write(A_EHI, 32'hFFFF_FFFF);
        accept("prio#1", 6'd2, 2, '0);
        accept("prio#2", 6'd9, 3, '0);
        accept("prio#3", 6'd33, 3, 64'd1 << 1);   // lower event arrives while held
        accept("prio#4", 6'd1, 1, '0);
        accept("prio#5", 6'd60, 1, '0);
        bus_read(A_PLO, d); chk("R10 all served lo", {32'd0, d}, 64'd0);
        bus_read(A_PHI, d); chk("R10 all served hi", {32'd0, d}, 64'd0);
        bus_write(A_ELO, 32'h0);
        bus_write(A_EHI, 32'h0);
    endtask

    task automatic t_set_wins_cpu();
        logic [31:0] d;
        pulse(64'd1 << 20);
        @(negedge clk);
        bus_addr = A_CLO; bus_wr = 1'b1; bus_wdata = 32'd1 << 20;
        evt_pulse = 64'd1 << 20;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0; evt_pulse = '0;
        bus_read(A_PLO, d); chk("R11 set beats cpu clear", {32'd0, d}, 64'h0010_0000);
        bus_write(A_CLO, 32'd1 << 20);
        bus_read(A_PLO, d); chk("R5 later cpu clear", {32'd0, d}, 64'd0);
    endtask

    task automatic t_set_wins_accept();
        logic [31:0] d;
        int waited = 0;
        bus_write(A_ELO, 32'd1 << 5);
        pulse(64'd1 << 5);
        while (!req_valid && waited < 10) begin
            @(negedge clk);
            waited++;
        end
        chk("R9 request for 5", {57'd0, req_valid, req_idx}, {57'd0, 1'b1, 6'd5});
        req_ready = 1'b1; evt_pulse = 64'd1 << 5;
        @(negedge clk);
        req_ready = 1'b0; evt_pulse = '0;
        chk("R10 gap after collide", {63'd0, req_valid}, 64'd0);
        accept("R11 re-request after collide", 6'd5, 1, '0);
        bus_read(A_PLO, d); chk("R10 cleared after second accept", {32'd0, d}, 64'd0);
        bus_write(A_ELO, 32'h0);
    endtask

    initial begin
        rst_n = 1'b0; evt_pulse = '0; bus_addr = '0; bus_wr = 1'b0;
        bus_wdata = '0; req_ready = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_sticky_disabled();
        t_clear_words();
        t_enable_rw();
        t_priority();
        t_set_wins_cpu();
        t_set_wins_accept();
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule